// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block sends one character at a time on an asynchronous serial line. A host loads a character of up to 9 bits into a single transmit holding register. On the next baud tick that finds the transmitter enabled, the holding register full and the configuration legal, the block builds the whole frame and shifts it out, one bit per baud tick period. The frame is a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Between frames the line rests high.

Control inputs set the character width (7, 8 or 9 bits), whether parity is sent and whether it is odd or even, and the number of stop bits. Two status outputs are kept apart. One shows that the holding register can take a new character. The other shows that the last frame has fully left the line. An illegal setting raises a configuration-error output, and no frame starts while that output is high.

Top module: `uart_frame_tx`

## Requirements
- R1: While reset is asserted and after its release, `txd` is 1, `tx_empty` is 1 and `tx_done` is 1.
- R2: `wlen` selects the character width: 2'b00 = 8 bits, 2'b01 = 9 bits, 2'b10 = 7 bits. The frame begins with a low start bit, followed by the data bits of `wr_data`, bit 0 first.
- R3: With `par_en` = 1, the parity bit takes the place of the top data bit inside the selected width, so only width-1 data bits are sent. With `par_odd` = 1 the data bits plus parity carry an odd number of ones; with `par_odd` = 0 they carry an even number.
- R4: `stop_code` 2'b00 sends one high stop bit and 2'b10 sends two. The line is high whenever no frame is in progress.
- R5: `cfg_err` is 1 in the same cycle that `wlen` = 2'b11 or `stop_code` is 2'b01 or 2'b11. While it is 1, no frame starts, and a pending character stays pending (`tx_empty` stays 0, `txd` stays 1).
- R6: A `wr_en` pulse while `tx_empty` = 1 captures `wr_data` and clears `tx_empty` one clock later. A `wr_en` pulse while `tx_empty` = 0 is ignored and does not change the character being sent or the one pending.
- R7: No frame starts while `tx_enable` is 0 or `tx_empty` is 1.
- R8: A frame starts on the first `baud_tick` cycle that meets the start conditions. The start bit appears on `txd` one clock later. Each later bit replaces the previous one one clock after each further tick. On the tick that ends the last stop bit, `tx_empty` and `tx_done` both rise, one clock later.
- R9: `tx_done` falls in the same clock in which the start bit appears, and it stays 0 until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| tx_enable | input | 1 | Allows frames to start |
| wlen | input | 2 | Character width code |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_code | input | 2 | Stop-bit count code |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | Holding register can take a character |
| tx_done | output | 1 | Last frame fully sent |
| cfg_err | output | 1 | Illegal configuration selected |

## Verification
`cfg_err` is combinational and is due in the cycle its inputs change. All other outputs come from registers and move exactly one clock after their cause: a write for `tx_empty`, a baud tick for `txd`, and the tick that ends the last stop bit for both flags. The bench drives inputs just after the falling edge. A behavioural model advances on each rising edge, and the outputs are compared with it on every falling edge, so each result is checked in the clock it is due. Directed checks then hold illegal or disabled settings for many ticks and confirm that the line and the flags do not move.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [1:0] {
      WL_8   = 2'b00,
      WL_9   = 2'b01,
      WL_7   = 2'b10,
      WL_BAD = 2'b11
   } wlen_e;

   typedef enum logic [1:0] {
      STOP_ONE = 2'b00,
      STOP_TWO = 2'b10
   } stop_e;

   // Number of character bits (data plus parity) for a width code
   function automatic logic [3:0] wlen_bits(input wlen_e code);
      case (code)
         WL_9:    return 4'd9;
         WL_7:    return 4'd7;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
   parameter int unsigned DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              start,
   input  logic              finish,
   output logic [DATA_W-1:0] tdr,
   output logic              empty,
   output logic              done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdr   <= '0;
         empty <= 1'b1;
         done  <= 1'b1;
      end else begin
         if (wr_en && empty) begin
            tdr   <= wr_data;
            empty <= 1'b0;
         end else if (finish) begin
            empty <= 1'b1;
         end
         if (finish) begin
            done <= 1'b1;
         end else if (start) begin
            done <= 1'b0;
         end
      end
   end

   // R6
   wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && empty) |=> !empty);

   // R9
   start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W  = 9,
   parameter int unsigned FRAME_W = DATA_W + 3,
   parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  tdr,
   input  logic [1:0]         wlen,
   input  logic               par_en,
   input  logic               par_odd,
   input  logic [1:0]         stop_code,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   frame_len,
   output logic               cfg_err
);

   logic [CNT_W-1:0]  nbits;
   logic [CNT_W-1:0]  ndat;
   logic [DATA_W-1:0] dmask;
   logic              par_bit;

   always_comb begin
      nbits = CNT_W'(wlen_bits(wlen_e'(wlen)));
      ndat  = nbits - CNT_W'(par_en);
      for (int i = 0; i < DATA_W; i++) begin
         dmask[i] = (CNT_W'(i) < ndat);
      end
      par_bit   = (^(tdr & dmask)) ^ par_odd;
      frame_len = CNT_W'(1) + nbits +
                  ((stop_e'(stop_code) == STOP_TWO) ? CNT_W'(2) : CNT_W'(1));
      cfg_err   = (wlen_e'(wlen) == WL_BAD) | stop_code[0];
   end

   // Parallel frame image: position 0 is the start bit, unused tail is stop level
   for (genvar p = 0; p < FRAME_W; p++) begin : g_bit
      localparam logic [CNT_W-1:0] PI = CNT_W'(p);
      if (p == 0) begin : g_start
         assign frame[p] = 1'b0;
      end else if (p - 1 < DATA_W) begin : g_data
         assign frame[p] = (PI <= ndat) ? tdr[p-1] :
                           (par_en && PI == ndat + CNT_W'(1)) ? par_bit : 1'b1;
      end else begin : g_tail
         assign frame[p] = (par_en && PI == ndat + CNT_W'(1)) ? par_bit : 1'b1;
      end
   end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
   parameter int unsigned FRAME_W = 12,
   parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               go_ok,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   frame_len,
   output logic               txd,
   output logic               busy,
   output logic               start,
   output logic               finish
);

   logic [FRAME_W-1:0] sreg;
   logic [CNT_W-1:0]   remain;

   assign start  = !busy && tick && go_ok;
   assign finish = busy && tick && (remain == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         txd    <= 1'b1;
         sreg   <= '1;
         remain <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         txd    <= frame[0];
         sreg   <= {1'b1, frame[FRAME_W-1:1]};
         remain <= frame_len - CNT_W'(1);
      end else if (busy && tick) begin
         if (remain == '0) begin
            busy <= 1'b0;
            txd  <= 1'b1;
         end else begin
            txd    <= sreg[0];
            sreg   <= {1'b1, sreg[FRAME_W-1:1]};
            remain <= remain - CNT_W'(1);
         end
      end
   end

   // R4
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R2
   start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !txd);

   // R8
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(txd));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
   parameter int unsigned DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_enable,
   input  logic [1:0]        wlen,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [1:0]        stop_code,
   input  logic              baud_tick,
   output logic              txd,
   output logic              tx_empty,
   output logic              tx_done,
   output logic              cfg_err
);

   localparam int unsigned FRAME_W = DATA_W + 3;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

   if (DATA_W != 9) begin : g_bad_width
      $error("uart_frame_tx: width codes require DATA_W of 9");
   end

   logic [DATA_W-1:0]  tdr;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   frame_len;
   logic               busy, start, finish, go_ok;

   assign go_ok = tx_enable && !tx_empty && !cfg_err;

   uart_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .start(start), .finish(finish),
      .tdr(tdr), .empty(tx_empty), .done(tx_done)
   );

   uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
      .tdr(tdr), .wlen(wlen), .par_en(par_en), .par_odd(par_odd),
      .stop_code(stop_code), .frame(frame), .frame_len(frame_len),
      .cfg_err(cfg_err)
   );

   uart_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .go_ok(go_ok),
      .frame(frame), .frame_len(frame_len),
      .txd(txd), .busy(busy), .start(start), .finish(finish)
   );

   // R5
   no_start_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(!cfg_err));

   // R7
   no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tx_enable));

   // R8
   end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (tx_empty && tx_done));

endmodule

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/100ps
module tb_uart_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic       tx_enable = 1'b0;
   logic [1:0] wlen = 2'b00;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic [1:0] stop_code = 2'b00;
   logic       baud_tick = 1'b0;
   logic       txd, tx_empty, tx_done, cfg_err;

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R2";
   int    tdiv = 0;

   always #2.5 clk = ~clk;

   uart_frame_tx dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tx_enable(tx_enable), .wlen(wlen), .par_en(par_en), .par_odd(par_odd),
      .stop_code(stop_code), .baud_tick(baud_tick),
      .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Baud tick: one cycle in four
   always @(negedge clk) begin
      tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == 3);
   end

   // Behavioural reference model
   int q[$];
   bit m_busy = 0, m_empty = 1, m_done = 1, m_txd = 1;
   int m_tdr = 0;

   always @(posedge clk) begin : model
      bit e0, err;
      int nb, nd, ones, b;
      if (!rst_n) begin
         q.delete();
         m_busy = 0; m_empty = 1; m_done = 1; m_txd = 1; m_tdr = 0;
      end else begin
         e0  = m_empty;
         err = (wlen == 2'b11) || stop_code[0];
         if (m_busy && baud_tick) begin
            if (q.size() == 0) begin
               m_busy = 0; m_txd = 1; m_empty = 1; m_done = 1;
            end else begin
               b = q.pop_front();
               m_txd = b[0];
            end
         end else if (!m_busy && baud_tick && tx_enable && !m_empty && !err) begin
            nb = (wlen == 2'b00) ? 8 : (wlen == 2'b01) ? 9 : 7;
            nd = nb - int'(par_en);
            ones = 0;
            for (int i = 0; i < nd; i++) begin
               q.push_back((m_tdr >> i) & 1);
               ones += (m_tdr >> i) & 1;
            end
            if (par_en) q.push_back((ones & 1) ^ int'(par_odd));
            q.push_back(1);
            if (stop_code == 2'b10) q.push_back(1);
            m_txd = 0; m_busy = 1; m_done = 0;
         end
         if (wr_en && e0) begin
            m_tdr = int'(wr_data);
            m_empty = 0;
         end
      end
   end

   // Compare on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(txd == m_txd, cur_req, "txd", txd, m_txd);
         check(tx_empty == m_empty, "R6", "tx_empty", tx_empty, m_empty);
         check(tx_done == m_done, "R9", "tx_done", tx_done, m_done);
         check(cfg_err == ((wlen == 2'b11) || stop_code[0]), "R5", "cfg_err",
               cfg_err, (wlen == 2'b11) || stop_code[0]);
      end
   end

   task automatic wr(input int d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_data = 9'(d);
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic cfg(input int wl, input bit pe, input bit po, input int sc);
      @(negedge clk); #1;
      wlen = 2'(wl); par_en = pe; par_odd = po; stop_code = 2'(sc);
   endtask

   task automatic wait_empty();
      int n = 0;
      while (!tx_empty && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check(n < 2000, "R8", "frame end timeout", n, 0);
      check(tx_empty && tx_done, "R8", "flags at frame end",
            int'(tx_empty) + int'(tx_done), 2);
   endtask

   task automatic send(input int d);
      wr(d);
      wait_empty();
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(txd == 1'b1, "R1", "txd in reset", txd, 1);
      check(tx_empty == 1'b1, "R1", "tx_empty in reset", tx_empty, 1);
      check(tx_done == 1'b1, "R1", "tx_done in reset", tx_done, 1);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(txd && tx_empty && tx_done, "R1", "state after release",
            int'(txd) + int'(tx_empty) + int'(tx_done), 3);

      tx_enable = 1'b1;
      // R2: widths 8, 9, 7
      cur_req = "R2";
      cfg(0, 0, 0, 0); send(9'h0A5);
      cfg(1, 0, 0, 0); send(9'h1C3);
      cfg(2, 0, 0, 0); send(9'h155);
      // R3: parity variants
      cur_req = "R3";
      cfg(0, 1, 0, 0); send(9'h0B7);
      cfg(0, 1, 1, 0); send(9'h0B7);
      cfg(1, 1, 1, 0); send(9'h1FE);
      cfg(2, 1, 0, 0); send(9'h03C);
      // R4: two stop bits
      cur_req = "R4";
      cfg(0, 0, 0, 2); send(9'h0FF);
      cfg(1, 1, 0, 2); send(9'h100);

      // R5: illegal width and half-bit stop codes
      cur_req = "R5";
      cfg(3, 0, 0, 0);
      wr(9'h012);
      repeat (40) @(negedge clk);
      check(cfg_err == 1'b1, "R5", "cfg_err for width 11", cfg_err, 1);
      check(tx_empty == 1'b0, "R5", "pending kept", tx_empty, 0);
      check(txd == 1'b1, "R5", "no start on bad width", txd, 1);
      cfg(0, 0, 0, 1);
      repeat (40) @(negedge clk);
      check(cfg_err == 1'b1, "R5", "cfg_err for stop 01", cfg_err, 1);
      check(txd == 1'b1 && !tx_empty, "R5", "no start on stop 01", txd, 1);
      cfg(0, 0, 0, 3);
      repeat (20) @(negedge clk);
      check(cfg_err == 1'b1, "R5", "cfg_err for stop 11", cfg_err, 1);
      cfg(0, 0, 0, 0);
      wait_empty();

      // R7: transmitter disabled
      cur_req = "R7";
      tx_enable = 1'b0;
      wr(9'h066);
      repeat (40) @(negedge clk);
      check(tx_empty == 1'b0, "R7", "pending while disabled", tx_empty, 0);
      check(tx_done == 1'b1, "R7", "no frame while disabled", tx_done, 1);
      check(txd == 1'b1, "R7", "line idle while disabled", txd, 1);
      tx_enable = 1'b1;
      wait_empty();

      // R6 and R9: write during a frame is ignored, done low during frame
      cur_req = "R6";
      wr(9'h0F0);
      while (txd) @(negedge clk);
      check(tx_done == 1'b0, "R9", "tx_done low at start bit", tx_done, 0);
      repeat (6) @(negedge clk);
      wr(9'h1FF);
      check(tx_empty == 1'b0, "R6", "ignored write keeps empty low", tx_empty, 0);
      check(tx_done == 1'b0, "R9", "tx_done low mid frame", tx_done, 0);
      wait_empty();

      // R8: back-to-back characters
      cur_req = "R8";
      send(9'h001);
      send(9'h080);
      cfg(1, 1, 0, 2); send(9'h0AA);
      repeat (8) @(negedge clk);
      check(txd && tx_empty && tx_done, "R4", "idle after last frame",
            int'(txd) + int'(tx_empty) + int'(tx_done), 3);

      finish_run();
   end

endmodule